// File: doc/BRIEF.md
# Serial Peripheral Master with Sequenced Status Flags

This block is a byte-wide SPI controller that a CPU drives through three small registers: a control register (enable, master select, rate code), a status register (transfer done, write collision, mode fault) and a data register. In master mode, a write to the data register starts an eight-bit transfer. SCK is derived from the system clock through a divider chosen by the rate code. Data goes out MSB first, using clock polarity 0 and phase 0: SCK idles low, MISO is sampled on the rising edge and the shift happens on the falling edge.

The flags are cleared only by a specific order of register accesses. A status read arms the clear, but only for flags that were already set at the time of that read. The next access then clears the armed flags: a data-register access clears transfer-done and write-collision, and a control-register write clears mode-fault. A data write that arrives while a transfer is running is rejected and raises write-collision. If slave select is pulled low while the master bit is set, the block raises mode-fault, aborts the transfer, clears the master and enable bits and releases the SCK and MOSI drivers. Received bytes are double buffered. Transmit has a single buffer, which is the shift register itself.

The shift engine is a three-state machine:
- SH_IDLE goes to SH_LEAD on an accepted data write.
- SH_LEAD (SCK low) goes to SH_TRAIL on a half-period tick and samples MISO.
- SH_TRAIL (SCK high) goes back to SH_LEAD on a tick while bits remain, shifting the sampled bit in.
- SH_TRAIL goes to SH_IDLE on the tick after the last bit, pulsing done.
- SH_LEAD and SH_TRAIL both go straight to SH_IDLE on a mode fault.

Top module: `spi_ctrl_top`

## Requirements
- R1: After reset, all three registers read 0x00, SCK is low and both output enables are low.
- R2: Control register layout is bit 0 enable, bit 1 master, bits 4:2 rate code. Rate codes 0 to 7 divide the system clock by 2, 4, 16, 32, 8, 16, 64 and 128 respectively, and a transfer lasts eight times the divisor in system clock cycles, counted from the cycle that accepts the data write.
- R3: Address 2 is the data register. Bytes shift out MSB first on MOSI, and MOSI is stable across each rising SCK edge. MISO is sampled on the rising edge, and the assembled byte is returned by data-register reads.
- R4: The status register is at address 1. Bit 7 (transfer done) sets in the same cycle that the eighth SCK period ends.
- R5: Transfer done clears only on a data-register access that follows a status read made while the flag was set. A data access with no such earlier read leaves it set.
- R6: A data write during a transfer sets bit 6 (write collision). It leaves the running transfer, its timing and its shifted data unchanged. It is cleared by the same sequence as R5.
- R7: When slave select is low while the master bit is 1, bit 4 (mode fault) sets, the transfer aborts without setting transfer done, the master and enable bits clear, and both output enables drop.
- R8: Mode fault clears only on a control write that follows a status read made while it was set. A control write without that read leaves it set.
- R9: Status bits 5 and 3 to 0 always read 0. Read data always shows the addressed register, and side effects happen only on the read strobe. Address 3 reads 0.
- R10: The last received byte stays readable while the next transfer runs, until that transfer completes.
- R11: A data write is ignored (no transfer, no SCK, no flag) unless both enable and master are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_rd | input | 1 | Read strobe, enables read side effects |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the addressed register |
| ss_n_i | input | 1 | Slave select input, low is a fault in master mode |
| miso_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | SCK driver enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | MOSI driver enable |

## Verification
The bench covers all eight rate codes and checks that transfer done is still clear one cycle before the expected end and set exactly at it. A divider with a mis-mapped code, or a bit counter off by one, would move that edge. Flag clearing is tested with unarmed accesses, including a status read taken while the flag was still clear; a design that cleared on any data access, or armed regardless of flag state, would drop the flag early. A colliding write is followed by a check that the slave still received the original byte, which catches designs that reload the shift register. A mid-transfer slave-select fault must leave transfer done clear and the control bits cleared, and it must survive a control write that has no status read before it.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    localparam int ST_DONE = 7;
    localparam int ST_WCOL = 6;
    localparam int ST_MODF = 4;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_LEAD  = 2'd1,
        SH_TRAIL = 2'd2
    } shift_state_t;

    // half of the SCK period, in system clocks, for each rate code
    function automatic logic [6:0] half_period(input logic [2:0] code);
        logic [6:0] h;
        unique case (code)
            3'd0: h = 7'd1;
            3'd1: h = 7'd2;
            3'd2: h = 7'd8;
            3'd3: h = 7'd16;
            3'd4: h = 7'd4;
            3'd5: h = 7'd8;
            3'd6: h = 7'd32;
            3'd7: h = 7'd64;
            default: h = 7'd1;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
    import spi_ctrl_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] rate_sel,
    output logic       tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(half_period(rate_sel) - 7'd1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_ctrl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] tx_data,
    input  logic          abort,
    input  logic          tick,
    input  logic          miso_i,
    output logic          busy,
    output logic          sck_o,
    output logic          mosi_o,
    output logic          done,
    output logic [DW-1:0] rx_data
);

    localparam int BC_W = $clog2(DW);

    shift_state_t  state_q, state_d;
    logic [DW-1:0] shreg_q;
    logic [DW-1:0] rx_q;
    logic [BC_W-1:0] bit_cnt_q;
    logic          miso_smp_q;
    logic          last_bit;

    assign last_bit = (bit_cnt_q == BC_W'(DW - 1));

    // next state and done pulse
    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        unique case (state_q)
            SH_IDLE: begin
                if (start) state_d = SH_LEAD;
            end
            SH_LEAD: begin
                if (abort)     state_d = SH_IDLE;
                else if (tick) state_d = SH_TRAIL;
            end
            SH_TRAIL: begin
                if (abort) begin
                    state_d = SH_IDLE;
                end else if (tick) begin
                    if (last_bit) begin
                        state_d = SH_IDLE;
                        done    = 1'b1;
                    end else begin
                        state_d = SH_LEAD;
                    end
                end
            end
            default: state_d = SH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            rx_q       <= '0;
            bit_cnt_q  <= '0;
            miso_smp_q <= 1'b0;
        end else begin
            unique case (state_q)
                SH_IDLE: begin
                    if (start) begin
                        shreg_q   <= tx_data;
                        bit_cnt_q <= '0;
                    end
                end
                SH_LEAD: begin
                    if (tick && !abort) miso_smp_q <= miso_i;
                end
                SH_TRAIL: begin
                    if (tick && !abort) begin
                        shreg_q   <= {shreg_q[DW-2:0], miso_smp_q};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                        if (last_bit) rx_q <= {shreg_q[DW-2:0], miso_smp_q};
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != SH_IDLE);
        sck_o   = (state_q == SH_TRAIL);
        mosi_o  = shreg_q[DW-1];
        rx_data = rx_q;
    end

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic wcol_evt,
    input  logic modf_evt,
    input  logic stat_rd,
    input  logic data_acc,
    input  logic ctrl_wr,
    output logic done_flag,
    output logic wcol_flag,
    output logic modf_flag,
    output logic arm_done
);

    logic arm_wcol_q, arm_modf_q, arm_done_q;

    assign arm_done = arm_done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag  <= 1'b0;
            wcol_flag  <= 1'b0;
            modf_flag  <= 1'b0;
            arm_done_q <= 1'b0;
            arm_wcol_q <= 1'b0;
            arm_modf_q <= 1'b0;
        end else begin
            // transfer done: set wins over the armed clear
            if (done)                         done_flag <= 1'b1;
            else if (data_acc && arm_done_q)  done_flag <= 1'b0;

            if (wcol_evt)                     wcol_flag <= 1'b1;
            else if (data_acc && arm_wcol_q)  wcol_flag <= 1'b0;

            if (modf_evt)                     modf_flag <= 1'b1;
            else if (ctrl_wr && arm_modf_q)   modf_flag <= 1'b0;

            // arming only happens for flags already set at the status read
            if (data_acc)                     arm_done_q <= 1'b0;
            else if (stat_rd && done_flag)    arm_done_q <= 1'b1;

            if (data_acc)                     arm_wcol_q <= 1'b0;
            else if (stat_rd && wcol_flag)    arm_wcol_q <= 1'b1;

            if (ctrl_wr)                      arm_modf_q <= 1'b0;
            else if (stat_rd && modf_flag)    arm_modf_q <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_ctrl_top.sv
module spi_ctrl_top
    import spi_ctrl_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CNT_W = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          ss_n_i,
    input  logic          miso_i,
    output logic          sck_o,
    output logic          sck_oe,
    output logic          mosi_o,
    output logic          mosi_oe
);

    logic       ctrl_en, ctrl_master;
    logic [2:0] ctrl_rate;
    logic       sh_busy, sh_done, tick;
    logic       done_flag, wcol_flag, modf_flag, arm_done;
    logic [DW-1:0] rx_data;

    logic ctrl_wr, stat_rd, data_wr, data_acc;
    logic modf_evt, start, wcol_evt;

    assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    assign stat_rd  = reg_rd && (reg_addr == A_STAT);
    assign data_wr  = reg_wr && (reg_addr == A_DATA);
    assign data_acc = (reg_rd || reg_wr) && (reg_addr == A_DATA);
    assign modf_evt = ctrl_master && !ss_n_i;
    assign start    = data_wr && ctrl_en && ctrl_master && !sh_busy && !modf_evt;
    assign wcol_evt = data_wr && sh_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en     <= 1'b0;
            ctrl_master <= 1'b0;
            ctrl_rate   <= 3'd0;
        end else begin
            if (ctrl_wr) begin
                ctrl_en     <= reg_wdata[0];
                ctrl_master <= reg_wdata[1];
                ctrl_rate   <= reg_wdata[4:2];
            end
            if (modf_evt) begin
                ctrl_en     <= 1'b0;
                ctrl_master <= 1'b0;
            end
        end
    end

    spi_baud_gen #(.CNT_W(CNT_W)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sh_busy),
        .rate_sel (ctrl_rate),
        .tick     (tick)
    );

    spi_shift_fsm #(.DW(DW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_data (reg_wdata),
        .abort   (modf_evt),
        .tick    (tick),
        .miso_i  (miso_i),
        .busy    (sh_busy),
        .sck_o   (sck_o),
        .mosi_o  (mosi_o),
        .done    (sh_done),
        .rx_data (rx_data)
    );

    spi_flag_unit u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (sh_done),
        .wcol_evt  (wcol_evt),
        .modf_evt  (modf_evt),
        .stat_rd   (stat_rd),
        .data_acc  (data_acc),
        .ctrl_wr   (ctrl_wr),
        .done_flag (done_flag),
        .wcol_flag (wcol_flag),
        .modf_flag (modf_flag),
        .arm_done  (arm_done)
    );

    assign sck_oe  = ctrl_en && ctrl_master;
    assign mosi_oe = ctrl_en && ctrl_master;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: reg_rdata = DW'({ctrl_rate, ctrl_master, ctrl_en});
            A_STAT: begin
                reg_rdata[ST_DONE] = done_flag;
                reg_rdata[ST_WCOL] = wcol_flag;
                reg_rdata[ST_MODF] = modf_flag;
            end
            A_DATA: reg_rdata = rx_data;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    reg_addr,
    input logic          reg_wr,
    input logic [DW-1:0] reg_rdata,
    input logic          ss_n_i,
    input logic          sck_o,
    input logic          sck_oe,
    input logic          mosi_oe,
    input logic          sh_busy,
    input logic          sh_done,
    input logic          done_flag,
    input logic          wcol_flag,
    input logic          modf_flag,
    input logic          arm_done,
    input logic          data_acc,
    input logic          ctrl_en,
    input logic          ctrl_master
);

    // R1
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_busy |-> !sck_o);

    // R4
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |=> done_flag);

    // R5
    done_hold_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && data_acc && !arm_done) |=> done_flag);

    // R6
    wcol_on_busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && sh_busy) |=> (wcol_flag && sh_busy));

    // R7
    modf_drops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_master && !ss_n_i) |=> (modf_flag && !ctrl_master && !ctrl_en && !sh_busy));

    // R7
    modf_releases_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(modf_flag) |-> (!sck_oe && !mosi_oe));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1) |-> (reg_rdata[5] == 1'b0 && reg_rdata[3:0] == 4'd0));

endmodule

bind spi_ctrl_top spi_ctrl_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_rdata   (reg_rdata),
    .ss_n_i      (ss_n_i),
    .sck_o       (sck_o),
    .sck_oe      (sck_oe),
    .mosi_oe     (mosi_oe),
    .sh_busy     (sh_busy),
    .sh_done     (sh_done),
    .done_flag   (done_flag),
    .wcol_flag   (wcol_flag),
    .modf_flag   (modf_flag),
    .arm_done    (arm_done),
    .data_acc    (data_acc),
    .ctrl_en     (ctrl_en),
    .ctrl_master (ctrl_master)
);

// File: tb/spi_ctrl_top_tb.sv
module spi_ctrl_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ss_n = 1'b1;
    logic       miso;
    logic       sck, sck_oe, mosi, mosi_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // slave model: counts falling edges, shifts MOSI in on rising edges
    int         falls = 0;
    int         slv_base = 0;
    logic [7:0] slv_byte = 8'd0;
    logic [7:0] slv_rx = 8'd0;
    int         slv_idx;

    always #4 clk = ~clk;

    spi_ctrl_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ss_n_i    (ss_n),
        .miso_i    (miso),
        .sck_o     (sck),
        .sck_oe    (sck_oe),
        .mosi_o    (mosi),
        .mosi_oe   (mosi_oe)
    );

    always @(negedge sck) falls <= falls + 1;
    always @(posedge sck) slv_rx <= {slv_rx[6:0], mosi};
    assign slv_idx = falls - slv_base;
    assign miso = (slv_idx >= 0 && slv_idx < 8) ? slv_byte[7 - slv_idx] : 1'b0;

    function automatic int div_of(input int code);
        case (code)
            0: return 2;   1: return 4;   2: return 16;  3: return 32;
            4: return 8;   5: return 16;  6: return 64;  default: return 128;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        peek(a, v);
        check(v == exp, tag, v, exp);
    endtask

    task automatic clear_done_wcol();
        logic [7:0] v;
        rd(2'd1, v);
        rd(2'd2, v);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        logic [7:0] v, tx, sb, prev;
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_reg(2'd0, 8'h00, "R1 ctrl");
        expect_reg(2'd1, 8'h00, "R1 status");
        expect_reg(2'd2, 8'h00, "R1 data");
        check(sck == 1'b0 && sck_oe == 1'b0 && mosi_oe == 1'b0, "R1 pins", {sck, sck_oe, mosi_oe}, 0);

        // R2 R3 R4 R5: sweep every rate code
        for (int code = 0; code < 8; code++) begin
            d  = div_of(code);
            tx = 8'h5A ^ 8'(code * 29);
            sb = ~tx + 8'(code);
            wr(2'd0, 8'((code << 2) | 3));
            slv_byte = sb;
            slv_base = falls;
            wr(2'd2, tx);
            repeat (8 * d - 1) @(negedge clk);
            expect_reg(2'd1, 8'h00, "R2 not done before 8*div");
            @(negedge clk);
            expect_reg(2'd1, 8'h80, "R4 R9 done at 8*div");
            check(slv_rx == tx, "R3 mosi byte", slv_rx, tx);
            expect_reg(2'd2, sb, "R3 rx byte");
            clear_done_wcol();
            expect_reg(2'd1, 8'h00, "R5 cleared by sequence");
        end

        // R5: status read while clear does not arm
        rd(2'd1, v);
        wr(2'd0, 8'h03);
        slv_base = falls; slv_byte = 8'h3C;
        wr(2'd2, 8'hA5);
        repeat (20) @(negedge clk);
        rd(2'd2, v);
        expect_reg(2'd1, 8'h80, "R5 stale arm ignored");
        rd(2'd2, v);
        expect_reg(2'd1, 8'h80, "R5 data access alone");
        clear_done_wcol();
        expect_reg(2'd1, 8'h00, "R5 clear after arm");

        // R10: previous byte readable during next transfer
        prev = 8'h3C;
        wr(2'd0, 8'h0F);
        slv_base = falls; slv_byte = 8'hC3;
        wr(2'd2, 8'h11);
        repeat (100) @(negedge clk);
        expect_reg(2'd2, prev, "R10 old byte mid transfer");
        repeat (200) @(negedge clk);
        expect_reg(2'd2, 8'hC3, "R10 new byte after done");
        clear_done_wcol();

        // R6: collision leaves transfer intact
        wr(2'd0, 8'h07);
        slv_base = falls; slv_byte = 8'h96;
        wr(2'd2, 8'h6B);
        wr(2'd2, 8'hFF);
        expect_reg(2'd1, 8'h40, "R6 wcol set");
        repeat (40) @(negedge clk);
        expect_reg(2'd1, 8'hC0, "R6 R9 done and wcol");
        check(slv_rx == 8'h6B, "R6 shifted byte kept", slv_rx, 8'h6B);
        expect_reg(2'd2, 8'h96, "R6 rx kept");
        rd(2'd2, v);
        expect_reg(2'd1, 8'hC0, "R6 unarmed access");
        clear_done_wcol();
        expect_reg(2'd1, 8'h00, "R6 cleared");

        // R11: ignored unless enable and master
        prev = slv_rx;
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h81);
        repeat (30) @(negedge clk);
        expect_reg(2'd1, 8'h00, "R11 no transfer without enable");
        check(slv_rx == prev && sck_oe == 1'b0, "R11 no sck", slv_rx, prev);
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h81);
        repeat (30) @(negedge clk);
        expect_reg(2'd1, 8'h00, "R11 no transfer without master");
        check(slv_rx == prev && sck == 1'b0, "R11 no shift", slv_rx, prev);

        // R7: fault mid-transfer
        wr(2'd0, 8'h1F);
        slv_base = falls; slv_byte = 8'h00;
        wr(2'd2, 8'hE7);
        repeat (200) @(negedge clk);
        ss_n = 1'b0;
        @(negedge clk);
        expect_reg(2'd1, 8'h10, "R7 R9 modf only");
        expect_reg(2'd0, 8'h1C, "R7 master and enable cleared");
        check(sck_oe == 1'b0 && mosi_oe == 1'b0 && sck == 1'b0, "R7 pins released",
              {sck_oe, mosi_oe, sck}, 0);
        ss_n = 1'b1;
        repeat (1100) @(negedge clk);
        expect_reg(2'd1, 8'h10, "R7 no done after abort");

        // R8: mode fault clear ordering
        wr(2'd0, 8'h1F);
        expect_reg(2'd1, 8'h10, "R8 ctrl write without read");
        rd(2'd1, v);
        wr(2'd0, 8'h1F);
        expect_reg(2'd1, 8'h00, "R8 cleared after read");
        expect_reg(2'd0, 8'h1F, "R8 ctrl rewritten");

        summary();
    end

endmodule